// File: doc/BRIEF.md
# Deterministic Bernstein Polynomial Evaluator

This block evaluates a Bernstein polynomial of degree DEG over unary bit streams. It does so exactly, with no random number source. One input value x is turned into DEG x-streams, and DEG+1 coefficient operands are turned into coefficient streams. Every stream comes from comparing a counter against an operand. The counters form a single mixed-radix chain of N-bit digits. Each digit steps only when every lower digit wraps, so over one full pass every combination of counter values appears exactly once.

Each cycle, the ones among the x-stream bits are added up to give a value from 0 to DEG. That value selects one coefficient stream bit, and an output counter accumulates the selected bits. All coefficient comparators share the fastest digit, because only one of their outputs is used in any cycle.

A run starts with a one-cycle start pulse and lasts 2^(N·(DEG+1)) cycles. The final count divided by 2^(N·(DEG+1)) is the exact value of the polynomial at x/2^N, with coefficients z_k/2^N.

Top module: `bern_det_eval`

## Requirements
- R1: After reset, count_out is 0 and done is 0.
- R2: A clock edge with start high clears count_out and done, which read 0 one cycle later. The same edge captures x_in and coef_in. Changes on those inputs after that edge have no effect on the result of the run.
- R3: Each converter emits 1 exactly when its counter value is strictly below its operand. An operand of 0 therefore gives an all-zero stream.
- R4: The counter chain has DEG+1 digits of N bits each. Digit 0 drives every coefficient comparator and steps every running cycle. Digit k steps only in a cycle where all lower digits hold all-ones, which is once per 2^(N·k) cycles. x-stream i, for i = 1..DEG, compares digit i against x.
- R5: The number of x-stream bits at 1 in a cycle, a value from 0 to DEG, selects coefficient z_k. z_k sits in coef_in bits [k·N +: N].
- R6: done first reads 1 exactly 2^(N·(DEG+1)) clock edges after the start edge, and never earlier in the run.
- R7: The final count_out equals the sum over k of C(DEG,k)·x^k·(2^N−x)^(DEG−k)·z_k. While running, the count never grows by more than 1 per cycle.
- R8: Once done is high, count_out and done hold their values until the next start.
- R9: A start pulse during a run abandons that run and begins a new one with the newly presented operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures the operands and begins a run |
| x_in | input | N | Evaluation point as a fraction of 2^N |
| coef_in | input | N·(DEG+1) | Coefficients z_0..z_DEG, with z_k at bits [k·N +: N] |
| count_out | output | N·(DEG+1) | Number of selected ones; the exact result once done is high |
| done | output | 1 | High from the end of a run until the next start |

## Verification
A digit that steps at the wrong moment, or a comparator with an off-by-one threshold, does not change done timing. It shows up only in the final count, so one full run of 2^(N·(DEG+1)) cycles is needed before such a fault can be seen. The operand vectors are chosen so that the terms of the Bernstein sum differ, which makes a swapped coefficient or a miscounted x-stream alter the total.

A fault in the control path shows up sooner. done arriving one cycle early or late, or a count that is not cleared by start, is visible within a cycle of the event. The bench also scrambles x_in and coef_in right after start, so any failure to capture the operands corrupts the result.

// File: rtl/bern_pkg.sv
package bern_pkg;

    // Width of the select value that counts 0..deg ones.
    function automatic int sel_bits(input int deg);
        return (deg < 2) ? 1 : $clog2(deg + 1);
    endfunction

endpackage

// File: rtl/bern_unary_cmp.sv
module bern_unary_cmp #(
    parameter int N = 2
) (
    input  logic [N-1:0] cnt_i,
    input  logic [N-1:0] level_i,
    output logic         bit_o
);

    // One unary bit: high while the running count is below the operand.
    assign bit_o = (cnt_i < level_i);

endmodule

// File: rtl/bern_ones_sum.sv
module bern_ones_sum #(
    parameter int DEG = 3,
    parameter int SW  = 2
) (
    input  logic [DEG-1:0] bits_i,
    output logic [SW-1:0]  sum_o
);

    always_comb begin
        sum_o = '0;
        for (int j = 0; j < DEG; j++) begin
            sum_o = sum_o + SW'(bits_i[j]);
        end
    end

endmodule

// File: rtl/bern_digit_chain.sv
module bern_digit_chain #(
    parameter int N   = 2,
    parameter int DEG = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   en,
    output logic [N*(DEG+1)-1:0]   digits,
    output logic                   wrap_all
);

    localparam int NUM = DEG + 1;

    logic [N-1:0] dig_d [NUM];
    logic [N-1:0] dig_q [NUM];
    logic [NUM-1:0] top_vec;
    logic [NUM-1:0] step_vec;

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_flat
            assign top_vec[g]          = (dig_q[g] == {N{1'b1}});
            assign digits[g*N +: N]    = dig_q[g];
        end
    endgenerate

    always_comb begin
        logic ripple;
        ripple = en;
        for (int k = 0; k < NUM; k++) begin
            step_vec[k] = ripple;
            ripple      = ripple & top_vec[k];
            if (clear) begin
                dig_d[k] = '0;
            end else if (step_vec[k]) begin
                dig_d[k] = dig_q[k] + 1'b1;
            end else begin
                dig_d[k] = dig_q[k];
            end
        end
        wrap_all = ripple;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM; k++) dig_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM; k++) dig_q[k] <= dig_d[k];
        end
    end

    generate
        for (g = 0; g < NUM; g++) begin : g_chk
            // R4
            digit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clear && step_vec[g]) |=> (dig_q[g] == N'($past(dig_q[g]) + 1'b1)));
            // R4
            digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clear && !step_vec[g]) |=> $stable(dig_q[g]));
        end
    endgenerate

    // R6
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_all && !clear) |=> (digits == '0));

endmodule

// File: rtl/bern_det_eval.sv
module bern_det_eval
    import bern_pkg::*;
#(
    parameter int N   = 2,
    parameter int DEG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N-1:0]         x_in,
    input  logic [N*(DEG+1)-1:0] coef_in,
    output logic [N*(DEG+1)-1:0] count_out,
    output logic                 done
);

    localparam int NUM   = DEG + 1;
    localparam int ZW    = N * NUM;
    localparam int ACC_W = N * NUM;
    localparam int SW    = sel_bits(DEG);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [ACC_W-1:0] acc;
        logic [N-1:0]     x;
        logic [ZW-1:0]    z;
    } eval_st_t;

    eval_st_t st_d, st_q;

    logic [ZW-1:0]  digits;
    logic           wrap_all;
    logic           chain_en;
    logic [NUM-1:0] zbit;
    logic [DEG-1:0] xbit;
    logic [SW-1:0]  sel;
    logic           sel_bit;

    assign chain_en = st_q.run && !start;

    bern_digit_chain #(.N(N), .DEG(DEG)) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .en       (chain_en),
        .digits   (digits),
        .wrap_all (wrap_all)
    );

    genvar g;
    generate
        // Coefficient comparators all share the fastest digit.
        for (g = 0; g < NUM; g++) begin : g_coef
            bern_unary_cmp #(.N(N)) cmp_i (
                .cnt_i   (digits[0 +: N]),
                .level_i (st_q.z[g*N +: N]),
                .bit_o   (zbit[g])
            );
        end
        // Each x-stream owns one slower digit.
        for (g = 0; g < DEG; g++) begin : g_xs
            bern_unary_cmp #(.N(N)) cmp_i (
                .cnt_i   (digits[(g+1)*N +: N]),
                .level_i (st_q.x),
                .bit_o   (xbit[g])
            );
        end
    endgenerate

    bern_ones_sum #(.DEG(DEG), .SW(SW)) sum_i (
        .bits_i (xbit),
        .sum_o  (sel)
    );

    assign sel_bit = zbit[sel];

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.run = 1'b1;
            st_d.fin = 1'b0;
            st_d.acc = '0;
            st_d.x   = x_in;
            st_d.z   = coef_in;
        end else if (st_q.run) begin
            st_d.acc = st_q.acc + ACC_W'(sel_bit);
            if (wrap_all) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_out = st_q.acc;
    assign done      = st_q.fin;

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_out == '0 && !done));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(count_out)));

    // R6
    done_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wrap_all));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !start) |=> (count_out == $past(count_out) ||
                                  count_out == ACC_W'($past(count_out) + 1'b1)));

endmodule

// File: tb/bern_det_eval_tb_top.sv
module bern_det_eval_tb_top;

    localparam int N     = 2;
    localparam int DEG   = 3;
    localparam int NUM   = DEG + 1;
    localparam int ACC_W = N * NUM;
    localparam int M     = 1 << N;
    localparam int T     = 1 << (N * NUM);
    localparam int NV    = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N-1:0]         x_in = '0;
    logic [N*NUM-1:0]     coef_in = '0;
    logic [ACC_W-1:0]     count_out;
    logic                 done;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bern_det_eval #(.N(N), .DEG(DEG)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .x_in      (x_in),
        .coef_in   (coef_in),
        .count_out (count_out),
        .done      (done)
    );

    // Stimulus rows: {x, z3, z2, z1, z0}; expected counts from the model below.
    localparam logic [N*(NUM+1)-1:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd1, 2'd3, 2'd2},
        {2'd3, 2'd3, 2'd0, 2'd1, 2'd2},
        {2'd1, 2'd2, 2'd2, 2'd2, 2'd2},
        {2'd2, 2'd3, 2'd2, 2'd1, 2'd0},
        {2'd1, 2'd0, 2'd3, 2'd0, 2'd3},
        {2'd2, 2'd0, 2'd0, 2'd0, 2'd0},
        {2'd3, 2'd3, 2'd3, 2'd3, 2'd3},
        {2'd2, 2'd1, 2'd3, 2'd0, 2'd2}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint binom(input int n, input int k);
        longint c = 1;
        for (int i = 0; i < k; i++) c = c * (n - i) / (i + 1);
        return c;
    endfunction

    function automatic longint model(input int x, input logic [N*NUM-1:0] z);
        longint s = 0;
        for (int k = 0; k <= DEG; k++) begin
            longint t = binom(DEG, k) * longint'(z[k*N +: N]);
            for (int j = 0; j < k; j++) t = t * x;
            for (int j = 0; j < DEG - k; j++) t = t * (M - x);
            s = s + t;
        end
        return s;
    endfunction

    task automatic launch(input logic [N-1:0] x, input logic [N*NUM-1:0] z);
        @(negedge clk);
        x_in    = x;
        coef_in = z;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        x_in    = ~x;
        coef_in = ~z;
    endtask

    task automatic run_vec(input logic [N-1:0] x, input logic [N*NUM-1:0] z);
        bit early = 1'b0;
        longint exp_v;
        launch(x, z);
        chk(count_out == '0 && done == 1'b0, "R2 start clears count and done", count_out, 0);
        for (int i = 1; i <= T; i++) begin
            @(posedge clk);
            #1;
            if (i < T && done) early = 1'b1;
        end
        chk(!early, "R6 done not before full pass", early, 0);
        chk(done == 1'b1, "R6 done after full pass", done, 1);
        exp_v = model(int'(x), z);
        // R3 R4 R5 R7: exact Bernstein sum at the ports
        chk(longint'(count_out) == exp_v, "R7 R5 R4 R3 final count", count_out, exp_v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [ACC_W-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        chk(count_out == '0, "R1 reset count", count_out, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][N*NUM +: N], VEC[v][N*NUM-1:0]);
        end

        // R8: result holds while idle, despite operand input changes
        held = count_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            x_in    = N'(i);
            coef_in = ~coef_in;
        end
        chk(count_out == held, "R8 count holds after done", count_out, held);
        chk(done == 1'b1, "R8 done holds", done, 1);

        // R9: restart in the middle of a run
        launch(2'd3, {2'd0, 2'd0, 2'd0, 2'd3});
        repeat (40) @(posedge clk);
        #1;
        chk(done == 1'b0, "R9 done low mid-run", done, 0);
        run_vec(2'd1, {2'd2, 2'd1, 2'd3, 2'd0});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule